// File: doc/BRIEF.md
# Message-Signalled Interrupt Doorbell Receiver

This block sits on a simple memory-mapped bus. It turns 32-bit message writes into set-pending requests for a bank of interrupt files. The address region holds one 4 KiB page per interrupt file. The page index selects the file. Within each page, only the word at offset zero acts as a doorbell. Its write data names the interrupt identity to mark pending. The interrupt-file storage downstream receives the file index, the identity and a one-cycle strobe. It performs the actual set.

Every access completes in the cycle it is presented. An access is rejected with an error in the same cycle in any of these cases:

- it is not word aligned;
- it is not four bytes wide;
- it falls outside the region.

Reads return zero. Well-formed writes have no effect in these cases:

- they land anywhere other than a page's doorbell word (including the reverse-byte-order doorbell at offset 4);
- they carry identity zero;
- they carry an identity at or above the configured count.

Such writes raise no error. The region base is a page-aligned parameter.

The control is a two-state machine. `ST_IDLE` is the state with no request outstanding. `ST_PULSE` is the state in which the strobe is high for the request captured at the previous edge. The transitions are:

- `IDLE_TO_PULSE` on an accepted doorbell hit;
- `PULSE_TO_PULSE` on a hit in the cycle of a pulse;
- `PULSE_TO_IDLE` when no hit follows;
- `IDLE_HOLD` while nothing arrives.

Top module: `msi_doorbell_rx`

## Requirements
- R1: While reset is asserted (active low, asynchronous) and in the first cycle after it, `set_pend` is 0 and `set_file` and `set_id` are 0; a reset arriving during a pulse drops it at once.
- R2: An access with `bus_addr[1:0]` not equal to 0 raises `bus_err` in the same cycle, for reads and writes alike, and produces no pulse.
- R3: An access whose `bus_bytes` is not 4 raises `bus_err` in the same cycle and produces no pulse.
- R4: An access below `REGION_BASE`, or at or above `REGION_BASE + NUM_FILES*4096`, raises `bus_err` and produces no pulse.
- R5: `bus_rdata` is always zero, and an aligned 4-byte read inside the region raises no error and produces no pulse.
- R6: An accepted write to page offset 0x000 with data d (1 <= d < `ID_COUNT`) makes `set_pend` high for exactly the next cycle, with `set_file` equal to (address - base) >> 12 and `set_id` equal to d.
- R7: An accepted write to any page offset other than 0x000, including 0x004, raises no error and produces no pulse.
- R8: A doorbell write carrying data 0 or data >= `ID_COUNT` raises no error and produces no pulse.
- R9: Doorbell hits in consecutive cycles give strobes in consecutive cycles, each carrying its own file and identity.
- R10: Whenever `set_pend` is 0, `set_file` and `set_id` are 0.
- R11: `bus_err` is 0 whenever `bus_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Access presented this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_bytes | input | 3 | Access width in bytes |
| bus_wdata | input | 32 | Write data (identity for a doorbell) |
| bus_rdata | output | 32 | Read data, always zero |
| bus_err | output | 1 | Same-cycle rejection of a bad access |
| set_pend | output | 1 | One-cycle set-pending strobe |
| set_file | output | FILE_W | Interrupt file index for the strobe |
| set_id | output | ID_W | Interrupt identity for the strobe |

## Verification
Several properties are checked on every cycle:

- misaligned and wrong-width accesses always raise an error;
- no error appears without a valid access;
- each strobe traces back to an error-free write, one cycle earlier, to a doorbell word carrying a legal identity;
- the payload outputs stay zero between strobes.

Other behaviours need the bench's scenarios:

- the exact file index and identity that reach the outputs;
- the out-of-region edges on both sides of the region;
- silent dropping at offset 4 and other offsets;
- back-to-back strobes;
- a reset that cuts a pulse short.

// File: rtl/msi_rx_pkg.sv
package msi_rx_pkg;

    // Outcome of decoding one bus access.
    typedef enum logic [1:0] {
        ACC_REJECT   = 2'd0,  // bad alignment, width or address
        ACC_READ     = 2'd1,  // good read, returns zero
        ACC_DOORBELL = 2'd2,  // good write to a page's offset-zero word
        ACC_INERT    = 2'd3   // good write anywhere else in a page
    } acc_kind_e;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_PULSE = 1'b1
    } rx_state_e;

    localparam int unsigned WORD_BYTES = 4;
    localparam int unsigned DATA_W     = 32;

endpackage

// File: rtl/msi_access_check.sv
module msi_access_check
    import msi_rx_pkg::*;
#(
    parameter int unsigned        ADDR_W      = 32,
    parameter int unsigned        PAGE_SHIFT  = 12,
    parameter int unsigned        NUM_FILES   = 4,
    parameter logic [ADDR_W-1:0]  REGION_BASE = 'h2800_0000,
    parameter int unsigned        FILE_W      = 2
) (
    input  logic              acc_valid,
    input  logic              acc_write,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [2:0]        acc_bytes,
    output acc_kind_e         acc_kind,
    output logic [FILE_W-1:0] acc_page
);

    localparam logic [ADDR_W-1:0] REGION_LEN = ADDR_W'(NUM_FILES) << PAGE_SHIFT;
    localparam int unsigned       LANE_W     = $clog2(WORD_BYTES);

    logic [ADDR_W-1:0] offset;
    logic              below_base;
    logic              past_end;
    logic              misaligned;
    logic              bad_width;
    logic              at_doorbell;

    assign offset      = acc_addr - REGION_BASE;
    assign below_base  = acc_addr < REGION_BASE;
    assign past_end    = offset >= REGION_LEN;
    assign misaligned  = |acc_addr[LANE_W-1:0];
    assign bad_width   = acc_bytes != 3'(WORD_BYTES);
    assign at_doorbell = offset[PAGE_SHIFT-1:0] == '0;

    // Page index: a single file has no index bits to decode.
    generate
        if (NUM_FILES > 1) begin : g_multi
            assign acc_page = offset[PAGE_SHIFT +: FILE_W];
        end else begin : g_single
            assign acc_page = '0;
        end
    endgenerate

    always_comb begin
        if (!acc_valid) begin
            acc_kind = ACC_INERT;
        end else if (misaligned || bad_width || below_base || past_end) begin
            acc_kind = ACC_REJECT;
        end else if (!acc_write) begin
            acc_kind = ACC_READ;
        end else if (at_doorbell) begin
            acc_kind = ACC_DOORBELL;
        end else begin
            acc_kind = ACC_INERT;
        end
    end

endmodule

// File: rtl/msi_id_filter.sv
module msi_id_filter
    import msi_rx_pkg::*;
#(
    parameter int unsigned ID_COUNT = 64,
    parameter int unsigned ID_W     = 6
) (
    input  logic [DATA_W-1:0] msg_data,
    output logic              msg_ok,
    output logic [ID_W-1:0]   msg_id
);

    // Identity zero is reserved; values at or above the count are ignored.
    assign msg_ok = (msg_data != '0) && (msg_data < DATA_W'(ID_COUNT));
    assign msg_id = msg_data[ID_W-1:0];

endmodule

// File: rtl/msi_doorbell_rx.sv
module msi_doorbell_rx
    import msi_rx_pkg::*;
#(
    parameter int unsigned       NUM_FILES   = 4,
    parameter int unsigned       ID_COUNT    = 64,
    parameter int unsigned       ADDR_W      = 32,
    parameter int unsigned       PAGE_SHIFT  = 12,
    parameter logic [ADDR_W-1:0] REGION_BASE = 'h2800_0000,
    localparam int unsigned      FILE_W      = (NUM_FILES > 1) ? $clog2(NUM_FILES) : 1,
    localparam int unsigned      ID_W        = $clog2(ID_COUNT)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [2:0]        bus_bytes,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              bus_err,
    output logic              set_pend,
    output logic [FILE_W-1:0] set_file,
    output logic [ID_W-1:0]   set_id
);

    acc_kind_e         kind;
    logic [FILE_W-1:0] page;
    logic              id_ok;
    logic [ID_W-1:0]   id;
    logic              hit;

    rx_state_e         state_q;
    rx_state_e         state_d;
    logic [FILE_W-1:0] file_q;
    logic [ID_W-1:0]   id_q;

    msi_access_check #(
        .ADDR_W      (ADDR_W),
        .PAGE_SHIFT  (PAGE_SHIFT),
        .NUM_FILES   (NUM_FILES),
        .REGION_BASE (REGION_BASE),
        .FILE_W      (FILE_W)
    ) u_access (
        .acc_valid (bus_valid),
        .acc_write (bus_write),
        .acc_addr  (bus_addr),
        .acc_bytes (bus_bytes),
        .acc_kind  (kind),
        .acc_page  (page)
    );

    msi_id_filter #(
        .ID_COUNT (ID_COUNT),
        .ID_W     (ID_W)
    ) u_idf (
        .msg_data (bus_wdata),
        .msg_ok   (id_ok),
        .msg_id   (id)
    );

    assign hit       = (kind == ACC_DOORBELL) && id_ok;
    assign bus_err   = (kind == ACC_REJECT);
    assign bus_rdata = '0;

    // Next-state selection.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  state_d = hit ? ST_PULSE : ST_IDLE;   // IDLE_TO_PULSE / IDLE_HOLD
            ST_PULSE: state_d = hit ? ST_PULSE : ST_IDLE;   // PULSE_TO_PULSE / PULSE_TO_IDLE
            default:  state_d = ST_IDLE;
        endcase
    end

    // State and captured payload.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            file_q  <= '0;
            id_q    <= '0;
        end else begin
            state_q <= state_d;
            if (hit) begin
                file_q <= page;
                id_q   <= id;
            end
        end
    end

    // Outputs from state.
    always_comb begin
        set_pend = 1'b0;
        set_file = '0;
        set_id   = '0;
        unique case (state_q)
            ST_IDLE: ;
            ST_PULSE: begin
                set_pend = 1'b1;
                set_file = file_q;
                set_id   = id_q;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/msi_doorbell_rx_chk.sv
module msi_doorbell_rx_chk #(
    parameter int unsigned ADDR_W     = 32,
    parameter int unsigned PAGE_SHIFT = 12,
    parameter int unsigned ID_COUNT   = 64,
    parameter int unsigned FILE_W     = 2,
    parameter int unsigned ID_W       = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_valid,
    input logic              bus_write,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [2:0]        bus_bytes,
    input logic [31:0]       bus_wdata,
    input logic              bus_err,
    input logic              set_pend,
    input logic [FILE_W-1:0] set_file,
    input logic [ID_W-1:0]   set_id
);

    assert_err_misalign_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && (bus_addr[1:0] != 2'b00)) |-> bus_err);

    assert_err_width_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && (bus_bytes != 3'd4)) |-> bus_err);

    assert_pend_source_R6: assert property (@(posedge clk) disable iff (!rst_n)
        set_pend |-> $past(bus_valid && bus_write && !bus_err));

    assert_pend_offset_R7: assert property (@(posedge clk) disable iff (!rst_n)
        set_pend |-> ($past(bus_addr[PAGE_SHIFT-1:0]) == '0));

    assert_pend_id_legal_R8: assert property (@(posedge clk) disable iff (!rst_n)
        set_pend |-> (($past(bus_wdata) != '0) && ($past(bus_wdata) < 32'(ID_COUNT)) && (set_id != '0)));

    assert_idle_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !set_pend |-> ((set_file == '0) && (set_id == '0)));

    assert_no_err_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_valid |-> !bus_err);

endmodule

bind msi_doorbell_rx msi_doorbell_rx_chk #(
    .ADDR_W     (ADDR_W),
    .PAGE_SHIFT (PAGE_SHIFT),
    .ID_COUNT   (ID_COUNT),
    .FILE_W     (FILE_W),
    .ID_W       (ID_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_valid (bus_valid),
    .bus_write (bus_write),
    .bus_addr  (bus_addr),
    .bus_bytes (bus_bytes),
    .bus_wdata (bus_wdata),
    .bus_err   (bus_err),
    .set_pend  (set_pend),
    .set_file  (set_file),
    .set_id    (set_id)
);

// File: tb/test_msi_doorbell_rx.sv
module test_msi_doorbell_rx;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        bus_valid;
    logic        bus_write;
    logic [31:0] bus_addr;
    logic [2:0]  bus_bytes;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata;
    logic        bus_err;
    logic        set_pend;
    logic [1:0]  set_file;
    logic [5:0]  set_id;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;  // 125 MHz

    msi_doorbell_rx i_msi_doorbell_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_valid (bus_valid),
        .bus_write (bus_write),
        .bus_addr  (bus_addr),
        .bus_bytes (bus_bytes),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .bus_err   (bus_err),
        .set_pend  (set_pend),
        .set_file  (set_file),
        .set_id    (set_id)
    );

    typedef struct packed {
        logic        wr;
        logic [31:0] addr;
        logic [2:0]  bytes;
        logic [31:0] data;
        logic        err;
        logic        pend;
        logic [1:0]  file;
        logic [5:0]  id;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 16;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 32'h2800_0000, 3'd4, 32'd5,          1'b0, 1'b1, 2'd0, 6'd5,  4'd6}, // R6
        '{1'b1, 32'h2800_3000, 3'd4, 32'd63,         1'b0, 1'b1, 2'd3, 6'd63, 4'd6}, // R6
        '{1'b1, 32'h2800_1000, 3'd4, 32'd1,          1'b0, 1'b1, 2'd1, 6'd1,  4'd6}, // R6
        '{1'b1, 32'h2800_2004, 3'd4, 32'd7,          1'b0, 1'b0, 2'd0, 6'd0,  4'd7}, // R7
        '{1'b1, 32'h2800_2010, 3'd4, 32'd7,          1'b0, 1'b0, 2'd0, 6'd0,  4'd7}, // R7
        '{1'b1, 32'h2800_0000, 3'd4, 32'd0,          1'b0, 1'b0, 2'd0, 6'd0,  4'd8}, // R8
        '{1'b1, 32'h2800_0000, 3'd4, 32'd64,         1'b0, 1'b0, 2'd0, 6'd0,  4'd8}, // R8
        '{1'b1, 32'h2800_2000, 3'd4, 32'hFFFF_FFFF,  1'b0, 1'b0, 2'd0, 6'd0,  4'd8}, // R8
        '{1'b1, 32'h2800_0002, 3'd4, 32'd5,          1'b1, 1'b0, 2'd0, 6'd0,  4'd2}, // R2
        '{1'b1, 32'h2800_1001, 3'd4, 32'd5,          1'b1, 1'b0, 2'd0, 6'd0,  4'd2}, // R2
        '{1'b1, 32'h2800_0000, 3'd2, 32'd5,          1'b1, 1'b0, 2'd0, 6'd0,  4'd3}, // R3
        '{1'b1, 32'h2800_0000, 3'd1, 32'd5,          1'b1, 1'b0, 2'd0, 6'd0,  4'd3}, // R3
        '{1'b1, 32'h2800_4000, 3'd4, 32'd5,          1'b1, 1'b0, 2'd0, 6'd0,  4'd4}, // R4
        '{1'b1, 32'h27FF_F000, 3'd4, 32'd5,          1'b1, 1'b0, 2'd0, 6'd0,  4'd4}, // R4
        '{1'b0, 32'h2800_1000, 3'd4, 32'd5,          1'b0, 1'b0, 2'd0, 6'd0,  4'd5}, // R5
        '{1'b0, 32'h2800_0003, 3'd4, 32'd5,          1'b1, 1'b0, 2'd0, 6'd0,  4'd2}  // R2
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic put(input logic v, input logic w, input logic [31:0] a,
                       input logic [2:0] b, input logic [31:0] d);
        bus_valid = v;
        bus_write = w;
        bus_addr  = a;
        bus_bytes = b;
        bus_wdata = d;
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        put(1'b0, 1'b0, 32'h0, 3'd4, 32'h0);
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        chk("R1 pend in reset", 32'(set_pend), 32'd0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 pend after reset", 32'(set_pend), 32'd0);
        chk("R1 file after reset", 32'(set_file), 32'd0);
        chk("R1 id after reset",   32'(set_id),   32'd0);

        // Vector table walk.
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            put(1'b1, VECS[i].wr, VECS[i].addr, VECS[i].bytes, VECS[i].data);
            #1;
            chk($sformatf("R%0d err vec%0d", VECS[i].req, i), 32'(bus_err), 32'(VECS[i].err));
            chk($sformatf("R5 rdata vec%0d", i), bus_rdata, 32'd0);
            @(negedge clk);
            put(1'b0, 1'b0, 32'h0, 3'd4, 32'h0);
            #1;
            chk($sformatf("R%0d pend vec%0d", VECS[i].req, i), 32'(set_pend), 32'(VECS[i].pend));
            chk($sformatf("R%0d file vec%0d", VECS[i].req, i), 32'(set_file), 32'(VECS[i].file));
            chk($sformatf("R%0d id vec%0d", VECS[i].req, i),   32'(set_id),   32'(VECS[i].id));
            @(negedge clk);
            chk($sformatf("R6 single pulse vec%0d", i), 32'(set_pend), 32'd0);
            chk($sformatf("R10 id idle vec%0d", i), 32'(set_id), 32'd0);
        end

        // R9: back-to-back doorbells.
        @(negedge clk);
        put(1'b1, 1'b1, 32'h2800_2000, 3'd4, 32'd9);
        @(negedge clk);
        put(1'b1, 1'b1, 32'h2800_1000, 3'd4, 32'd33);
        #1;
        chk("R9 first pend", 32'(set_pend), 32'd1);
        chk("R9 first file", 32'(set_file), 32'd2);
        chk("R9 first id",   32'(set_id),   32'd9);
        @(negedge clk);
        put(1'b0, 1'b0, 32'h0, 3'd4, 32'h0);
        #1;
        chk("R9 second pend", 32'(set_pend), 32'd1);
        chk("R9 second file", 32'(set_file), 32'd1);
        chk("R9 second id",   32'(set_id),   32'd33);
        @(negedge clk);
        chk("R10 pend low after burst", 32'(set_pend), 32'd0);
        chk("R10 file low after burst", 32'(set_file), 32'd0);

        // R11: bad address without valid raises no error.
        put(1'b0, 1'b1, 32'h0000_0003, 3'd1, 32'd5);
        #1;
        chk("R11 err without valid", 32'(bus_err), 32'd0);
        @(negedge clk);
        chk("R11 no pend without valid", 32'(set_pend), 32'd0);

        // R1: reset during a pulse.
        put(1'b1, 1'b1, 32'h2800_3000, 3'd4, 32'd12);
        @(negedge clk);
        put(1'b0, 1'b0, 32'h0, 3'd4, 32'h0);
        #1;
        chk("R6 pend before reset", 32'(set_pend), 32'd1);
        rst_n = 1'b0;
        #1;
        chk("R1 pend cut by reset", 32'(set_pend), 32'd0);
        chk("R1 id cut by reset",   32'(set_id),   32'd0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 pend after second reset", 32'(set_pend), 32'd0);

        finish_run();
    end

endmodule